// File: doc/BRIEF.md
# Snooping Bus Coherence Controller

This block sits beside one processor's private cache on a shared-bus multiprocessor. It keeps per-line coherence state for a small direct-mapped cache. Each line holds a state (absent, shared or exclusive), a dirty flag, a tag and one data word. The controller accepts processor reads and writes through a ready/valid handshake. It raises bus transactions when a request cannot be served locally. A write to an exclusive line stays in the cache. A write to a shared line is broadcast on the bus so that other copies and memory see the new value.

The controller also observes every transaction that other agents place on the bus. When another agent reads a line that this cache holds, the controller reports the line as shared, demotes an exclusive copy and supplies the data if its copy is dirty. When another agent broadcasts a write, the held copy takes the new data. Bus arbitration, memory and the other caches are outside the block.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is absent, `bus_req_o` is low, and the first access to any address needs a bus read.
- R2: A read miss issues one bus read (command 2'b00). The line is installed exclusive if `bus_shared_i` is low at completion and shared otherwise. A read hit needs no bus transaction and returns the line's word.
- R3: A write to an exclusive line completes with no bus transaction and marks the line dirty. Only exclusive lines are ever dirty.
- R4: A write to a shared line issues exactly one write broadcast (command 2'b01) carrying the request's address and data. The line stays shared and clean.
- R5: A write miss first fills the line with a bus read. It then completes as R3 or R4, according to the state installed.
- R6: A snooped bus read (`snp_cmd_i` 2'b00) to a held line raises `snp_shared_o` in the same cycle. An exclusive line becomes shared.
- R7: If that snooped read hits a dirty line, `snp_supply_o` is raised with the line's word on `snp_data_o`, and the line becomes clean.
- R8: A snooped write broadcast (2'b01) to a held line replaces the line's word with `snp_wdata_i` and leaves the line shared.
- R9: A miss whose victim is dirty first writes the victim back (command 2'b10) with the victim's address and word. The fill follows.
- R10: `req_ready_o` is never high while a bus request is pending. A pending request keeps its command and address until the cycle with both `bus_gnt_i` and `bus_done_i` high.
- R11: In a cycle with `snp_valid_i` high the processor request is not accepted.
- R12: Snoops to lines that are not held, and snooped write-backs, leave the outputs `snp_shared_o` and `snp_supply_o` low and the cache contents unchanged.

The line index is the low `IDX_W` bits of the word address, and the tag is the remaining bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid, held until accepted |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_rdata_o | output | DATA_W | Read data, valid with ready on a read |
| bus_req_o | output | 1 | Bus transaction pending |
| bus_cmd_o | output | 2 | 00 read, 01 write broadcast, 10 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Broadcast or write-back data |
| bus_gnt_i | input | 1 | Bus granted to this cache |
| bus_done_i | input | 1 | Transaction completes (with grant) |
| bus_rdata_i | input | DATA_W | Fill data at completion |
| bus_shared_i | input | 1 | Another cache holds the filled line |
| snp_valid_i | input | 1 | Another agent's transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_wdata_i | input | DATA_W | Snooped broadcast data |
| snp_shared_o | output | 1 | This cache holds the snooped line (reads) |
| snp_supply_o | output | 1 | This cache supplies dirty data |
| snp_data_o | output | DATA_W | Supplied data |

## Verification
The assertions assume that snoops never coincide with this cache's own grant, and that the processor holds its request stable until it is accepted. They also assume that no other agent broadcasts a write to a line this cache holds exclusively. The bench keeps within these rules. It applies snoops only between processor operations. It holds every request until ready, and it turns any random snooped write to a line that the reference model holds exclusive into a snooped read. Other caches are modeled as holding only clean copies, so memory stays correct except for this cache's dirty lines.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    CS_INV = 2'd0,
    CS_SHD = 2'd1,
    CS_EXC = 2'd2
  } cstate_e;

  typedef enum logic [1:0] {
    BC_READ   = 2'd0,
    BC_UPDATE = 2'd1,
    BC_WBACK  = 2'd2
  } bcmd_e;
endpackage

// File: rtl/coh_store.sv
module coh_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // processor-side lookup
  input  logic [IDX_W-1:0]  idx_i,
  output cstate_e           rd_state_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_dirty_o,
  // local line write
  input  logic              lw_en_i,
  input  logic [IDX_W-1:0]  lw_idx_i,
  input  cstate_e           lw_state_i,
  input  logic [TAG_W-1:0]  lw_tag_i,
  input  logic [DATA_W-1:0] lw_data_i,
  input  logic              lw_dirty_i,
  // snoop port
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic [TAG_W-1:0]  snp_tag_i,
  input  logic [DATA_W-1:0] snp_wdata_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int LINES = 1 << IDX_W;

  cstate_e           st_q    [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] data_q  [LINES];
  logic              dirty_q [LINES];
  logic              snp_hit;

  assign rd_state_o = st_q[idx_i];
  assign rd_tag_o   = tag_q[idx_i];
  assign rd_data_o  = data_q[idx_i];
  assign rd_dirty_o = dirty_q[idx_i];

  assign snp_hit      = snp_valid_i && (st_q[snp_idx_i] != CS_INV) && (tag_q[snp_idx_i] == snp_tag_i);
  assign snp_shared_o = snp_hit && (snp_cmd_i == BC_READ);
  assign snp_supply_o = snp_shared_o && dirty_q[snp_idx_i];
  assign snp_data_o   = data_q[snp_idx_i];

  // snoop effects take priority over local writes to the same line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]    <= CS_INV;
        tag_q[i]   <= '0;
        data_q[i]  <= '0;
        dirty_q[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snp_hit && snp_idx_i == IDX_W'(i)) begin
          if (snp_cmd_i == BC_READ) begin
            if (st_q[i] == CS_EXC) st_q[i] <= CS_SHD;
            dirty_q[i] <= 1'b0;
          end else if (snp_cmd_i == BC_UPDATE) begin
            st_q[i]    <= CS_SHD;
            data_q[i]  <= snp_wdata_i;
            dirty_q[i] <= 1'b0;
          end
        end else if (lw_en_i && lw_idx_i == IDX_W'(i)) begin
          st_q[i]    <= lw_state_i;
          tag_q[i]   <= lw_tag_i;
          data_q[i]  <= lw_data_i;
          dirty_q[i] <= lw_dirty_i;
        end
      end
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_chk
    p_dirty_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dirty_q[g] |-> st_q[g] == CS_EXC);
    p_snoop_demote_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snp_shared_o && snp_idx_i == IDX_W'(g)) |=> (st_q[g] == CS_SHD && !dirty_q[g]));
    p_snoop_update_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snp_hit && snp_cmd_i == BC_UPDATE && snp_idx_i == IDX_W'(g))
      |=> (st_q[g] == CS_SHD && data_q[g] == $past(snp_wdata_i)));
  end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_we_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  output logic                    req_ready_o,
  input  logic                    snp_valid_i,
  input  cstate_e                 rd_state_i,
  input  logic [ADDR_W-IDX_W-1:0] rd_tag_i,
  input  logic [DATA_W-1:0]       rd_data_i,
  input  logic                    rd_dirty_i,
  output logic                    lw_en_o,
  output cstate_e                 lw_state_o,
  output logic [ADDR_W-IDX_W-1:0] lw_tag_o,
  output logic [DATA_W-1:0]       lw_data_o,
  output logic                    lw_dirty_o,
  output logic                    bus_req_o,
  output logic [1:0]              bus_cmd_o,
  output logic [ADDR_W-1:0]       bus_addr_o,
  output logic [DATA_W-1:0]       bus_wdata_o,
  input  logic                    bus_gnt_i,
  input  logic                    bus_done_i,
  input  logic [DATA_W-1:0]       bus_rdata_i,
  input  logic                    bus_shared_i
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_WBACK, S_FILL, S_UPD, S_DONE} seq_e;
  seq_e st_q, st_d;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit, bus_fin;
  bcmd_e            cmd;

  assign idx       = req_addr_i[IDX_W-1:0];
  assign tag       = req_addr_i[ADDR_W-1:IDX_W];
  assign hit       = (rd_state_i != CS_INV) && (rd_tag_i == tag);
  assign bus_fin   = bus_gnt_i && bus_done_i;
  assign bus_cmd_o = cmd;

  always_comb begin
    st_d        = st_q;
    req_ready_o = 1'b0;
    bus_req_o   = 1'b0;
    cmd         = BC_READ;
    bus_addr_o  = req_addr_i;
    bus_wdata_o = req_wdata_i;
    lw_en_o     = 1'b0;
    lw_state_o  = rd_state_i;
    lw_tag_o    = rd_tag_i;
    lw_data_o   = rd_data_i;
    lw_dirty_o  = rd_dirty_i;
    unique case (st_q)
      S_IDLE: if (req_valid_i && !snp_valid_i) begin
        if (hit) begin
          if (!req_we_i) req_ready_o = 1'b1;
          else if (rd_state_i == CS_EXC) begin
            req_ready_o = 1'b1;
            lw_en_o     = 1'b1;
            lw_data_o   = req_wdata_i;
            lw_dirty_o  = 1'b1;
          end else st_d = S_UPD;
        end else begin
          st_d = (rd_state_i != CS_INV && rd_dirty_i) ? S_WBACK : S_FILL;
        end
      end
      S_WBACK: begin
        bus_req_o   = 1'b1;
        cmd         = BC_WBACK;
        bus_addr_o  = {rd_tag_i, idx};
        bus_wdata_o = rd_data_i;
        if (bus_fin) begin
          lw_en_o    = 1'b1;
          lw_state_o = CS_INV;
          lw_dirty_o = 1'b0;
          st_d       = S_FILL;
        end
      end
      S_FILL: begin
        bus_req_o = 1'b1;
        cmd       = BC_READ;
        if (bus_fin) begin
          lw_en_o    = 1'b1;
          lw_state_o = bus_shared_i ? CS_SHD : CS_EXC;
          lw_tag_o   = tag;
          lw_data_o  = bus_rdata_i;
          lw_dirty_o = 1'b0;
          st_d       = S_IDLE;
        end
      end
      S_UPD: begin
        bus_req_o = 1'b1;
        cmd       = BC_UPDATE;
        if (bus_fin) begin
          lw_en_o    = 1'b1;
          lw_state_o = CS_SHD;
          lw_data_o  = req_wdata_i;
          lw_dirty_o = 1'b0;
          st_d       = S_DONE;
        end
      end
      S_DONE: if (!snp_valid_i) begin
        req_ready_o = 1'b1;
        st_d        = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  p_ready_no_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_req_o);
  p_hold_txn_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_fin) |=> (bus_req_o && $stable(bus_cmd_o) && $stable(bus_addr_o)));
  p_snoop_not_granted_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i |-> !bus_gnt_i);
  p_lw_only_bus_or_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lw_en_o && !bus_req_o) |-> (req_ready_o && req_we_i));
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_gnt_i,
  input  logic              bus_done_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [DATA_W-1:0] snp_wdata_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  cstate_e           rd_state, lw_state;
  logic [TAG_W-1:0]  rd_tag, lw_tag;
  logic [DATA_W-1:0] rd_data, lw_data;
  logic              rd_dirty, lw_dirty, lw_en;

  assign req_rdata_o = rd_data;

  coh_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .idx_i       (req_addr_i[IDX_W-1:0]),
    .rd_state_o  (rd_state),
    .rd_tag_o    (rd_tag),
    .rd_data_o   (rd_data),
    .rd_dirty_o  (rd_dirty),
    .lw_en_i     (lw_en),
    .lw_idx_i    (req_addr_i[IDX_W-1:0]),
    .lw_state_i  (lw_state),
    .lw_tag_i    (lw_tag),
    .lw_data_i   (lw_data),
    .lw_dirty_i  (lw_dirty),
    .snp_valid_i,
    .snp_cmd_i,
    .snp_idx_i   (snp_addr_i[IDX_W-1:0]),
    .snp_tag_i   (snp_addr_i[ADDR_W-1:IDX_W]),
    .snp_wdata_i,
    .snp_shared_o,
    .snp_supply_o,
    .snp_data_o
  );

  coh_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_we_i, .req_addr_i, .req_wdata_i, .req_ready_o,
    .snp_valid_i,
    .rd_state_i  (rd_state),
    .rd_tag_i    (rd_tag),
    .rd_data_i   (rd_data),
    .rd_dirty_i  (rd_dirty),
    .lw_en_o     (lw_en),
    .lw_state_o  (lw_state),
    .lw_tag_o    (lw_tag),
    .lw_data_o   (lw_data),
    .lw_dirty_o  (lw_dirty),
    .bus_req_o, .bus_cmd_o, .bus_addr_o, .bus_wdata_o,
    .bus_gnt_i, .bus_done_i, .bus_rdata_i, .bus_shared_i
  );
endmodule

// File: tb/tb_snoop_coh_ctrl.sv
module tb_snoop_coh_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;
  localparam int NADDR  = 32;
  localparam int NLINE  = 1 << IDX_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_we_i = 0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic req_ready_o;
  logic [DATA_W-1:0] req_rdata_o;
  logic bus_req_o;
  logic [1:0] bus_cmd_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [DATA_W-1:0] bus_wdata_o;
  logic bus_gnt_i = 0, bus_done_i = 0, bus_shared_i = 0;
  logic [DATA_W-1:0] bus_rdata_i = '0;
  logic snp_valid_i = 0;
  logic [1:0] snp_cmd_i = 0;
  logic [ADDR_W-1:0] snp_addr_i = '0;
  logic [DATA_W-1:0] snp_wdata_i = '0;
  logic snp_shared_o, snp_supply_o;
  logic [DATA_W-1:0] snp_data_o;

  snoop_coh_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit summary_done = 0;

  // reference model: 0 absent, 1 shared, 2 exclusive
  int m_st [NLINE];
  int m_tag [NLINE];
  bit m_dirty [NLINE];
  logic [DATA_W-1:0] golden [NADDR];
  logic [DATA_W-1:0] mem [NADDR];
  bit others [NADDR];

  task automatic check(input bit ok, input string rq, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // bus responder for one pending transaction; starts and ends at a negedge
  task automatic serve(input logic [DATA_W-1:0] exp_wdata);
    logic [1:0] c0 = bus_cmd_o;
    logic [ADDR_W-1:0] a0 = bus_addr_o;
    int a;
    repeat ($urandom % 3) begin
      @(negedge clk_i);
      check(bus_req_o && bus_cmd_o == c0 && bus_addr_o == a0, "R10 hold", bus_addr_o, a0);
    end
    a = int'(bus_addr_o) % NADDR;
    bus_gnt_i = 1;
    bus_done_i = 1;
    bus_rdata_i = mem[a];
    bus_shared_i = others[a];
    if (bus_cmd_o == 2'b01) begin
      check(bus_wdata_o == exp_wdata, "R4 bcast data", bus_wdata_o, exp_wdata);
      mem[a] = bus_wdata_o;
    end else if (bus_cmd_o == 2'b10) begin
      mem[a] = bus_wdata_o;
    end
    @(negedge clk_i);
    bus_gnt_i = 0;
    bus_done_i = 0;
    bus_shared_i = 0;
  endtask

  task automatic proc_op(input bit we, input int addr, input logic [DATA_W-1:0] wd);
    int idx = addr % NLINE, tg = addr / NLINE, exp_n = 0, n = 0, guard = 0;
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    string lbl = "R2";
    logic [DATA_W-1:0] exp_rd = golden[addr];
    if (!hit) begin
      if (m_st[idx] != 0 && m_dirty[idx]) begin exp_n++; lbl = "R9"; end
      exp_n++;
      if (we && lbl != "R9") lbl = "R5";
      m_st[idx] = others[addr] ? 1 : 2;
      m_tag[idx] = tg;
      m_dirty[idx] = 0;
    end
    if (we) begin
      if (m_st[idx] == 1) begin exp_n++; if (hit) lbl = "R4"; end
      else begin m_dirty[idx] = 1; if (hit) lbl = "R3"; end
      golden[addr] = wd;
    end
    req_valid_i = 1; req_we_i = we; req_addr_i = ADDR_W'(addr); req_wdata_i = wd;
    #1;
    forever begin
      if (req_ready_o) break;
      if (bus_req_o) begin serve(wd); n++; end
      else @(negedge clk_i);
      #1;
      if (++guard > 60) break;
    end
    check(req_ready_o, {lbl, " ready"}, DATA_W'(req_ready_o), 1);
    if (!we) check(req_rdata_o == exp_rd, {lbl, " rdata"}, req_rdata_o, exp_rd);
    check(n == exp_n, {lbl, " bus count"}, DATA_W'(n), DATA_W'(exp_n));
    @(posedge clk_i); #1;
    req_valid_i = 0;
    @(negedge clk_i);
  endtask

  task automatic snoop(input logic [1:0] cmd, input int addr, input logic [DATA_W-1:0] wd);
    int idx = addr % NLINE, tg = addr / NLINE;
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    bit e_sh = (cmd == 2'b00) && hit;
    bit e_su = e_sh && m_dirty[idx];
    snp_valid_i = 1; snp_cmd_i = cmd; snp_addr_i = ADDR_W'(addr); snp_wdata_i = wd;
    #1;
    check(snp_shared_o == e_sh, e_sh ? "R6 shared" : "R12 shared", DATA_W'(snp_shared_o), DATA_W'(e_sh));
    check(snp_supply_o == e_su, e_su ? "R7 supply" : "R12 supply", DATA_W'(snp_supply_o), DATA_W'(e_su));
    if (e_su) check(snp_data_o == golden[addr], "R7 data", snp_data_o, golden[addr]);
    if (cmd == 2'b00) begin
      others[addr] = 1;
      if (hit) begin
        if (e_su) mem[addr] = golden[addr];
        m_dirty[idx] = 0;
        if (m_st[idx] == 2) m_st[idx] = 1;
      end
    end else if (cmd == 2'b01) begin
      others[addr] = 1;
      mem[addr] = wd;
      golden[addr] = wd;
      if (hit) m_st[idx] = 1;
    end
    @(posedge clk_i); #1;
    snp_valid_i = 0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NLINE; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dirty[i] = 0; end
    for (int i = 0; i < NADDR; i++) begin
      golden[i] = 32'h1000_0000 + 32'(i * 32'h111);
      mem[i] = golden[i];
      others[i] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(bus_req_o == 0, "R1 bus idle", DATA_W'(bus_req_o), 0);
    check(req_ready_o == 0, "R1 no ready", DATA_W'(req_ready_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    check(bus_req_o == 0, "R1 idle after reset", DATA_W'(bus_req_o), 0);
    proc_op(0, 3, '0);                  // R1/R2 miss -> exclusive
    proc_op(1, 3, 32'hA5A5_0003);       // R3 silent write
    snoop(2'b00, 3, '0);                // R6/R7 demote and supply
    proc_op(1, 3, 32'hB0B0_0003);       // R4 broadcast
    others[11] = 1;
    proc_op(0, 11, '0);                 // R2 shared install, clean victim
    proc_op(1, 11, 32'hC0C0_000B);      // R4
    proc_op(1, 19, 32'hD0D0_0013);      // R5 write miss -> exclusive
    proc_op(1, 27, 32'hE0E0_001B);      // R9 dirty victim
    proc_op(0, 19, '0);                 // R9 reads back written-back word
    others[4] = 1;
    proc_op(0, 4, '0);
    snoop(2'b01, 4, 32'h7777_0004);     // R8 update
    proc_op(0, 4, '0);                  // R8 new data, no bus
    proc_op(1, 4, 32'h8888_0004);       // R8 still shared -> broadcast
    snoop(2'b00, 30, '0);               // R12 not held
    snoop(2'b10, 4, mem[4]);            // R12 write-back ignored
    proc_op(0, 4, '0);                  // R12 contents unchanged
    // R11: snoop cycle blocks acceptance
    proc_op(0, 5, '0);
    req_valid_i = 1; req_we_i = 0; req_addr_i = ADDR_W'(5);
    snp_valid_i = 1; snp_cmd_i = 2'b10; snp_addr_i = ADDR_W'(21); snp_wdata_i = mem[21];
    #1;
    check(req_ready_o == 0, "R11 stall", DATA_W'(req_ready_o), 0);
    @(posedge clk_i); #1;
    snp_valid_i = 0;
    @(negedge clk_i); #1;
    check(req_ready_o == 1, "R11 resume", DATA_W'(req_ready_o), 1);
    check(req_rdata_o == golden[5], "R11 data", req_rdata_o, golden[5]);
    @(posedge clk_i); #1;
    req_valid_i = 0;
    @(negedge clk_i);
    // random mix
    for (int k = 0; k < 500; k++) begin
      int a = int'($urandom % NADDR);
      int r = int'($urandom % 10);
      int ix = a % NLINE;
      if (r < 7) proc_op(r < 3, a, $urandom);
      else if (r < 9) begin
        logic [1:0] c = ($urandom % 2 == 0) ? 2'b00 : 2'b01;
        if (c == 2'b01 && m_st[ix] == 2 && m_tag[ix] == a / NLINE) c = 2'b00;
        snoop(c, a, $urandom);
      end else if (!(m_st[ix] != 0 && m_tag[ix] == a / NLINE)) others[a] = 0;
    end
    finish_run();
  end
endmodule